// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the byte-wide control port of a NAND-style flash device model or controller front end. Each write strobe carries one bus cycle, tagged by the command-latch and address-latch lines. The block sorts each cycle into command, address, data or invalid. It gathers address bytes into column and row fields and follows the legal command sequences. When a sequence completes, it raises a one-cycle operation request that carries the decoded kind, column, row and bank index.

Operations that start array activity (page read, copy read, program, copy program, erase) set a busy flag. That flag stays set until the surrounding model pulses a clear input or a reset command arrives. A bad byte, a byte that arrives out of order, or a cycle with both latch lines high produces a one-cycle error pulse. The sequence in progress is then dropped. Data-write cycles carry no decode meaning and are passed over. The array timing and the data path belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, busy, op_valid and err_pulse are all low.
- R2: A strobed cycle with cle=1, ale=0 is a command, and one with ale=1, cle=0 is an address byte. With both high the cycle is invalid and gives an error pulse. With both low it is a data cycle: it neither changes the sequence nor raises an error or an operation.
- R3: Command 00h, then four address bytes, then 30h issues kind 1 (page read) and sets busy. The four bytes are taken in order as column low, column high, row low and row high. If 35h replaces 30h, the request is kind 2 (copy read).
- R4: With the decoder idle and not busy, 05h, then two column bytes, then E0h issues kind 3 (random output). The request carries the new column and the row from the previous sequence.
- R5: Command 80h, then four address bytes, then any data cycles, then 10h issues kind 4 (program) and sets busy. During the data phase, 85h followed by two column bytes issues kind 6 (random input) with the new column, and the data phase then resumes.
- R6: In the data phase, 11h issues kind 5 (chain) and op_bank set to the index of the bank just closed. After that, only 80h is accepted. At most MAX_BANKS banks can be set up in one chain. A 11h in the last allowed bank is an error. The final 10h reports the last bank index.
- R7: With the decoder idle, 85h, then four address bytes, then 10h issues kind 7 (copy program) and sets busy.
- R8: Command 60h, then two address bytes, then D0h issues kind 8 (erase) and sets busy. The two bytes fill the row field, low byte first.
- R9: Command FFh is accepted in every state, including while busy. It issues kind 10 (reset), clears busy and returns the decoder to idle.
- R10: An undefined command byte, a defined command that arrives outside its place in a sequence, or an address byte that no sequence expects gives an error pulse and no operation. The decoder then returns to idle.
- R11: While busy, command 70h issues kind 9 (status) and FFh issues reset. Any other command or address byte gives an error pulse. Data cycles are passed over. A pulse on busy_clr drops busy.
- R12: Each request is one cycle long and shows up in the clock cycle after the strobe that completes the sequence. A request and an error pulse are never high together. op_col and op_row are valid while op_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write cycle |
| cle | input | 1 | Command-latch line, sampled with the strobe |
| ale | input | 1 | Address-latch line, sampled with the strobe |
| io_in | input | 8 | Bus byte, sampled with the strobe |
| busy_clr | input | 1 | Pulse from the array model that ends the busy period |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Operation code (see R3 to R11) |
| op_col | output | 8*COL_CYC | Column address |
| op_row | output | 8*ROW_CYC | Row address |
| op_bank | output | BANK_W | Bank index for chain and program requests |
| busy | output | 1 | Array operation in progress |
| err_pulse | output | 1 | One-cycle rejection of a bad cycle |

## Verification
The assertions assume that wr_stb is already synchronous to clk and lasts one cycle per bus cycle. They also assume that cle, ale and io_in are valid whenever wr_stb is high. The bench drives each bus cycle as a single strobe cycle followed by a quiet cycle, with the latch lines and the byte held for the whole strobe. It pulses busy_clr only between bus cycles, so no check depends on how a clear and a new busy start are ordered within one cycle. The random part draws legal read, program and erase sequences and undefined command bytes, and it ends each run with a clear or a reset so that every draw starts from idle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [3:0] {
      OPK_NONE      = 4'd0,
      OPK_PAGE_READ = 4'd1,
      OPK_COPY_READ = 4'd2,
      OPK_RAND_OUT  = 4'd3,
      OPK_PROGRAM   = 4'd4,
      OPK_CHAIN     = 4'd5,
      OPK_RAND_IN   = 4'd6,
      OPK_COPY_PROG = 4'd7,
      OPK_ERASE     = 4'd8,
      OPK_STATUS    = 4'd9,
      OPK_RESET     = 4'd10
   } op_kind_t;

   typedef enum logic [2:0] {
      CYC_NONE,
      CYC_CMD,
      CYC_ADDR,
      CYC_DATA,
      CYC_BAD
   } cyc_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_ADDR,
      ST_RD_CONF,
      ST_RO_ADDR,
      ST_RO_CONF,
      ST_PG_ADDR,
      ST_PG_DATA,
      ST_RI_ADDR,
      ST_CHAIN,
      ST_CB_ADDR,
      ST_CB_CONF,
      ST_ER_ADDR,
      ST_ER_CONF
   } seq_st_t;

   localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
   localparam logic [7:0] CMD_RAND_OUT    = 8'h05;
   localparam logic [7:0] CMD_PROG_GO     = 8'h10;
   localparam logic [7:0] CMD_BANK_NEXT   = 8'h11;
   localparam logic [7:0] CMD_READ_GO     = 8'h30;
   localparam logic [7:0] CMD_COPY_RD_GO  = 8'h35;
   localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
   localparam logic [7:0] CMD_STATUS      = 8'h70;
   localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
   localparam logic [7:0] CMD_RAND_IN     = 8'h85;
   localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
   localparam logic [7:0] CMD_RO_GO       = 8'hE0;
   localparam logic [7:0] CMD_RESET       = 8'hFF;

endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
   import fcd_pkg::*;
(
   input  logic stb,
   input  logic cle,
   input  logic ale,
   output cyc_t cyc
);

   always_comb begin
      if (!stb)
         cyc = CYC_NONE;
      else if (cle && ale)
         cyc = CYC_BAD;
      else if (cle)
         cyc = CYC_CMD;
      else if (ale)
         cyc = CYC_ADDR;
      else
         cyc = CYC_DATA;
   end

endmodule

// File: rtl/fcd_addr_slots.sv
module fcd_addr_slots #(
   parameter int NSLOT = 4,
   localparam int IDX_W = $clog2(NSLOT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_byte,
   output logic [8*NSLOT-1:0] slots_flat
);

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            slot_q <= wr_byte;
      end
      assign slots_flat[8*g +: 8] = slot_q;
   end

   a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NSLOT));

endmodule

// File: rtl/fcd_seq_ctrl.sv
module fcd_seq_ctrl
   import fcd_pkg::*;
#(
   parameter int COL_CYC   = 2,
   parameter int ROW_CYC   = 2,
   parameter int MAX_BANKS = 4,
   localparam int NSLOT  = COL_CYC + ROW_CYC,
   localparam int SLOT_W = $clog2(NSLOT + 1),
   localparam int CNT_W  = $clog2(MAX_BANKS + 1),
   localparam int BANK_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_t              cyc,
   input  logic [7:0]        cmd_byte,
   input  logic              busy_clr,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_idx,
   output logic              op_valid,
   output op_kind_t          op_kind,
   output logic [BANK_W-1:0] op_bank,
   output logic              busy,
   output logic              err
);

   seq_st_t           st_q, st_n;
   logic [SLOT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0]  bank_q, bank_n;
   logic              busy_q, busy_n;
   logic              vld_q, vld_n;
   op_kind_t          kind_q, kind_n;
   logic [BANK_W-1:0] obank_q, obank_n;
   logic              err_q;
   logic              fail;
   logic [SLOT_W-1:0] len;
   logic [SLOT_W-1:0] base;
   logic [BANK_W-1:0] bank_idx;

   assign bank_idx = (bank_q == '0) ? '0 : BANK_W'(bank_q - CNT_W'(1));

   always_comb begin
      case (st_q)
         ST_RD_ADDR, ST_PG_ADDR, ST_CB_ADDR: len = SLOT_W'(NSLOT);
         ST_RO_ADDR, ST_RI_ADDR:             len = SLOT_W'(COL_CYC);
         ST_ER_ADDR:                         len = SLOT_W'(ROW_CYC);
         default:                            len = '0;
      endcase
      base = (st_q == ST_ER_ADDR) ? SLOT_W'(COL_CYC) : '0;
   end

   always_comb begin
      st_n    = st_q;
      cnt_n   = cnt_q;
      bank_n  = bank_q;
      busy_n  = busy_q & ~busy_clr;
      vld_n   = 1'b0;
      kind_n  = OPK_NONE;
      obank_n = obank_q;
      wr_en   = 1'b0;
      wr_idx  = base + cnt_q;
      fail    = 1'b0;

      if (cyc == CYC_BAD) begin
         fail = 1'b1;
      end else if (cyc == CYC_CMD && cmd_byte == CMD_RESET) begin
         vld_n  = 1'b1;
         kind_n = OPK_RESET;
         busy_n = 1'b0;
         st_n   = ST_IDLE;
         cnt_n  = '0;
         bank_n = '0;
      end else if (busy_q) begin
         if (cyc == CYC_CMD && cmd_byte == CMD_STATUS) begin
            vld_n  = 1'b1;
            kind_n = OPK_STATUS;
         end else if (cyc == CYC_CMD || cyc == CYC_ADDR) begin
            fail = 1'b1;
         end
      end else if (cyc == CYC_ADDR) begin
         if (len == '0) begin
            fail = 1'b1;
         end else begin
            wr_en = 1'b1;
            if (cnt_q == len - SLOT_W'(1)) begin
               cnt_n = '0;
               case (st_q)
                  ST_RD_ADDR: st_n = ST_RD_CONF;
                  ST_RO_ADDR: st_n = ST_RO_CONF;
                  ST_PG_ADDR: st_n = ST_PG_DATA;
                  ST_CB_ADDR: st_n = ST_CB_CONF;
                  ST_ER_ADDR: st_n = ST_ER_CONF;
                  default: begin
                     st_n   = ST_PG_DATA;
                     vld_n  = 1'b1;
                     kind_n = OPK_RAND_IN;
                  end
               endcase
            end else begin
               cnt_n = cnt_q + SLOT_W'(1);
            end
         end
      end else if (cyc == CYC_CMD) begin
         cnt_n = '0;
         case (st_q)
            ST_IDLE: begin
               case (cmd_byte)
                  CMD_READ_SETUP:  st_n = ST_RD_ADDR;
                  CMD_RAND_OUT:    st_n = ST_RO_ADDR;
                  CMD_RAND_IN:     st_n = ST_CB_ADDR;
                  CMD_ERASE_SETUP: st_n = ST_ER_ADDR;
                  CMD_PROG_SETUP: begin
                     st_n   = ST_PG_ADDR;
                     bank_n = CNT_W'(1);
                  end
                  CMD_STATUS: begin
                     vld_n  = 1'b1;
                     kind_n = OPK_STATUS;
                  end
                  default: fail = 1'b1;
               endcase
            end
            ST_RD_CONF: begin
               if (cmd_byte == CMD_READ_GO || cmd_byte == CMD_COPY_RD_GO) begin
                  vld_n  = 1'b1;
                  kind_n = (cmd_byte == CMD_READ_GO) ? OPK_PAGE_READ : OPK_COPY_READ;
                  busy_n = 1'b1;
                  st_n   = ST_IDLE;
               end else begin
                  fail = 1'b1;
               end
            end
            ST_RO_CONF: begin
               if (cmd_byte == CMD_RO_GO) begin
                  vld_n  = 1'b1;
                  kind_n = OPK_RAND_OUT;
                  st_n   = ST_IDLE;
               end else begin
                  fail = 1'b1;
               end
            end
            ST_PG_DATA: begin
               if (cmd_byte == CMD_PROG_GO) begin
                  vld_n   = 1'b1;
                  kind_n  = OPK_PROGRAM;
                  obank_n = bank_idx;
                  busy_n  = 1'b1;
                  bank_n  = '0;
                  st_n    = ST_IDLE;
               end else if (cmd_byte == CMD_RAND_IN) begin
                  st_n = ST_RI_ADDR;
               end else if (cmd_byte == CMD_BANK_NEXT && int'(bank_q) < MAX_BANKS) begin
                  vld_n   = 1'b1;
                  kind_n  = OPK_CHAIN;
                  obank_n = bank_idx;
                  st_n    = ST_CHAIN;
               end else begin
                  fail = 1'b1;
               end
            end
            ST_CHAIN: begin
               if (cmd_byte == CMD_PROG_SETUP) begin
                  st_n   = ST_PG_ADDR;
                  bank_n = bank_q + CNT_W'(1);
               end else begin
                  fail = 1'b1;
               end
            end
            ST_CB_CONF: begin
               if (cmd_byte == CMD_PROG_GO) begin
                  vld_n  = 1'b1;
                  kind_n = OPK_COPY_PROG;
                  busy_n = 1'b1;
                  st_n   = ST_IDLE;
               end else begin
                  fail = 1'b1;
               end
            end
            ST_ER_CONF: begin
               if (cmd_byte == CMD_ERASE_GO) begin
                  vld_n  = 1'b1;
                  kind_n = OPK_ERASE;
                  busy_n = 1'b1;
                  st_n   = ST_IDLE;
               end else begin
                  fail = 1'b1;
               end
            end
            default: fail = 1'b1;
         endcase
      end

      if (fail) begin
         vld_n  = 1'b0;
         kind_n = OPK_NONE;
         wr_en  = 1'b0;
         if (!busy_q) begin
            st_n   = ST_IDLE;
            cnt_n  = '0;
            bank_n = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         bank_q  <= '0;
         busy_q  <= 1'b0;
         vld_q   <= 1'b0;
         kind_q  <= OPK_NONE;
         obank_q <= '0;
         err_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         cnt_q   <= cnt_n;
         bank_q  <= bank_n;
         busy_q  <= busy_n;
         vld_q   <= vld_n;
         kind_q  <= kind_n;
         obank_q <= vld_n ? obank_n : '0;
         err_q   <= fail;
      end
   end

   assign op_valid = vld_q;
   assign op_kind  = kind_q;
   assign op_bank  = obank_q;
   assign busy     = busy_q;
   assign err      = err_q;

   // R9: a reset command always clears busy and is reported
   a_r9_reset_any_state: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_CMD && cmd_byte == CMD_RESET) |=> (!busy_q && vld_q && kind_q == OPK_RESET));

   a_r11_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cyc == CYC_CMD && cmd_byte != CMD_RESET && cmd_byte != CMD_STATUS)
      |=> (err_q && !vld_q));

   a_r2_bad_cycle_err: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_BAD) |=> err_q);

   a_r12_req_vs_err: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_q && err_q));

   a_r6_bank_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bank_q) <= MAX_BANKS);

   a_r3_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (vld_q && (kind_q == OPK_PAGE_READ || kind_q == OPK_COPY_READ ||
                                   kind_q == OPK_PROGRAM || kind_q == OPK_COPY_PROG ||
                                   kind_q == OPK_ERASE)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int COL_CYC   = 2,
   parameter int ROW_CYC   = 2,
   parameter int MAX_BANKS = 4,
   localparam int NSLOT  = COL_CYC + ROW_CYC,
   localparam int SLOT_W = $clog2(NSLOT + 1),
   localparam int COL_W  = 8 * COL_CYC,
   localparam int ROW_W  = 8 * ROW_CYC,
   localparam int BANK_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              cle,
   input  logic              ale,
   input  logic [7:0]        io_in,
   input  logic              busy_clr,
   output logic              op_valid,
   output logic [3:0]        op_kind,
   output logic [COL_W-1:0]  op_col,
   output logic [ROW_W-1:0]  op_row,
   output logic [BANK_W-1:0] op_bank,
   output logic              busy,
   output logic              err_pulse
);

   if (COL_CYC < 1 || ROW_CYC < 1) begin : g_bad_addr_cfg
      $error("flash_cmd_decoder: column and row need at least one byte each");
   end
   if (MAX_BANKS < 1 || MAX_BANKS > 16) begin : g_bad_bank_cfg
      $error("flash_cmd_decoder: MAX_BANKS must lie in 1..16");
   end

   cyc_t              cyc;
   logic              wr_en;
   logic [SLOT_W-1:0] wr_idx;
   logic [8*NSLOT-1:0] slots;
   op_kind_t          kind;

   fcd_cycle_class i_class (
      .stb (wr_stb),
      .cle (cle),
      .ale (ale),
      .cyc (cyc)
   );

   fcd_seq_ctrl #(
      .COL_CYC   (COL_CYC),
      .ROW_CYC   (ROW_CYC),
      .MAX_BANKS (MAX_BANKS)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc      (cyc),
      .cmd_byte (io_in),
      .busy_clr (busy_clr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .op_valid (op_valid),
      .op_kind  (kind),
      .op_bank  (op_bank),
      .busy     (busy),
      .err      (err_pulse)
   );

   fcd_addr_slots #(
      .NSLOT (NSLOT)
   ) i_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_byte    (io_in),
      .slots_flat (slots)
   );

   assign op_kind = kind;
   assign op_col  = slots[COL_W-1:0];
   assign op_row  = slots[8*NSLOT-1:COL_W];

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic        cle = 1'b0;
   logic        ale = 1'b0;
   logic [7:0]  io_in = 8'h00;
   logic        busy_clr = 1'b0;
   logic        op_valid;
   logic [3:0]  op_kind;
   logic [15:0] op_col;
   logic [15:0] op_row;
   logic [1:0]  op_bank;
   logic        busy;
   logic        err_pulse;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic        g_v, g_e, g_busy;
   logic [3:0]  g_k;
   logic [15:0] g_c, g_r;
   logic [1:0]  g_b;

   always #(CLK_P/2) clk = ~clk;

   flash_cmd_decoder i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
      .io_in(io_in), .busy_clr(busy_clr), .op_valid(op_valid), .op_kind(op_kind),
      .op_col(op_col), .op_row(op_row), .op_bank(op_bank), .busy(busy),
      .err_pulse(err_pulse)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic capture();
      g_v = op_valid; g_e = err_pulse; g_k = op_kind; g_c = op_col;
      g_r = op_row; g_b = op_bank; g_busy = busy;
   endtask

   task automatic bus(logic c, logic a, logic [7:0] b);
      @(negedge clk);
      wr_stb = 1'b1; cle = c; ale = a; io_in = b;
      @(negedge clk);
      wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
      capture();
   endtask

   task automatic cmd(logic [7:0] b);  bus(1'b1, 1'b0, b); endtask
   task automatic adr(logic [7:0] b);  bus(1'b0, 1'b1, b); endtask
   task automatic dat(logic [7:0] b);  bus(1'b0, 1'b0, b); endtask

   task automatic adr4(logic [15:0] c, logic [15:0] r);
      adr(c[7:0]); adr(c[15:8]); adr(r[7:0]); adr(r[15:8]);
   endtask

   task automatic clr_busy();
      @(negedge clk); busy_clr = 1'b1;
      @(negedge clk); busy_clr = 1'b0;
   endtask

   task automatic expect_op(string tag, int k);
      chk({tag, " valid"}, 32'(g_v), 32'd1);
      chk({tag, " kind"}, 32'(g_k), 32'(k));
      chk({tag, " no err"}, 32'(g_e), 32'd0);
   endtask

   task automatic expect_err(string tag);
      chk({tag, " err"}, 32'(g_e), 32'd1);
      chk({tag, " no op"}, 32'(g_v), 32'd0);
   endtask

   function automatic bit idle_defined(logic [7:0] b);
      return b == 8'h00 || b == 8'h05 || b == 8'h80 || b == 8'h85 ||
             b == 8'h60 || b == 8'h70 || b == 8'hFF;
   endfunction

   function automatic int kind_for_confirm(logic [7:0] b);
      return (b == 8'h30) ? 1 : 2;
   endfunction

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      capture();
      // R1 reset state
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 op_valid", 32'(op_valid), 32'd0);
      chk("R1 err", 32'(err_pulse), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R3 page read
      cmd(8'h00); adr4(16'h1234, 16'hABCD);
      chk("R12 no early op", 32'(g_v), 32'd0);
      cmd(8'h30);
      expect_op("R3 read", 1);
      chk("R3 col", 32'(g_c), 32'h1234);
      chk("R3 row", 32'(g_r), 32'hABCD);
      chk("R3 busy", 32'(g_busy), 32'd1);
      @(negedge clk);
      chk("R12 single cycle", 32'(op_valid), 32'd0);

      // R11 status and rejection while busy
      cmd(8'h70); expect_op("R11 status busy", 9);
      cmd(8'h00); expect_err("R11 read while busy");
      adr(8'h01); expect_err("R11 addr while busy");
      dat(8'h55);
      chk("R11 data ignored err", 32'(g_e), 32'd0);
      chk("R11 still busy", 32'(g_busy), 32'd1);
      clr_busy(); capture();
      chk("R11 busy cleared", 32'(g_busy), 32'd0);

      // R4 random output keeps row
      cmd(8'h05); adr(8'h77); adr(8'h06); cmd(8'hE0);
      expect_op("R4 rand out", 3);
      chk("R4 col", 32'(g_c), 32'h0677);
      chk("R4 row", 32'(g_r), 32'hABCD);

      // R3 copy read, R7 copy program
      cmd(8'h00); adr4(16'h0010, 16'h2000); cmd(8'h35);
      expect_op("R3 copy read", 2);
      clr_busy();
      cmd(8'h85); adr4(16'h0020, 16'h3001); cmd(8'h10);
      expect_op("R7 copy prog", 7);
      chk("R7 row", 32'(g_r), 32'h3001);
      chk("R7 busy", 32'(g_busy), 32'd1);
      // R9 reset while busy
      cmd(8'hFF);
      expect_op("R9 reset busy", 10);
      chk("R9 busy cleared", 32'(g_busy), 32'd0);

      // R5 program with random input
      cmd(8'h80); adr4(16'h0100, 16'h0040);
      dat(8'h11); dat(8'h22);
      chk("R2 data no err", 32'(g_e), 32'd0);
      cmd(8'h85); adr(8'h08); adr(8'h02);
      expect_op("R5 rand in", 6);
      chk("R5 rand in col", 32'(g_c), 32'h0208);
      dat(8'h33); cmd(8'h10);
      expect_op("R5 program", 4);
      chk("R5 bank", 32'(g_b), 32'd0);
      clr_busy();

      // R6 chain four banks then overflow
      cmd(8'h80); adr4(16'h0, 16'h0001);
      for (int i = 0; i < 3; i++) begin
         cmd(8'h11);
         expect_op("R6 chain", 5);
         chk("R6 chain bank", 32'(g_b), 32'(i));
         cmd(8'h80); adr4(16'h0, 16'(i + 2));
      end
      cmd(8'h11); expect_err("R6 fifth bank");
      cmd(8'h10); expect_err("R10 confirm after abort");
      cmd(8'h80); adr4(16'h0, 16'h0009); cmd(8'h11);
      cmd(8'h80); adr4(16'h0, 16'h000A); cmd(8'h10);
      expect_op("R6 chained program", 4);
      chk("R6 last bank", 32'(g_b), 32'd1);
      clr_busy();
      cmd(8'h80); adr4(16'h0, 16'h0); cmd(8'h11); cmd(8'h30);
      expect_err("R6 only setup after chain");

      // R8 erase
      cmd(8'h60); adr(8'h5A); adr(8'hC3); cmd(8'hD0);
      expect_op("R8 erase", 8);
      chk("R8 row", 32'(g_r), 32'hC35A);
      cmd(8'hFF);

      // R2 invalid cycle, R10 misplaced items
      bus(1'b1, 1'b1, 8'h00); expect_err("R2 both latches");
      adr(8'h12); expect_err("R10 addr in idle");
      cmd(8'h00); adr(8'h1); cmd(8'h30); expect_err("R10 early confirm");
      cmd(8'h30); expect_err("R10 confirm in idle");
      cmd(8'h00); adr4(16'h1, 16'h2); adr(8'h3); expect_err("R10 fifth addr");
      cmd(8'h60); adr(8'h1); cmd(8'hFF); expect_op("R9 reset mid addr", 10);
      cmd(8'hD0); expect_err("R9 back to idle");
      cmd(8'h70); expect_op("R11 status idle", 9);

      // random mix
      for (int n = 0; n < 60; n++) begin
         int pick;
         logic [15:0] c, r;
         logic [7:0] b;
         pick = int'($urandom_range(0, 3));
         c = 16'($urandom); r = 16'($urandom);
         case (pick)
            0: begin
               b = ($urandom_range(0, 1) == 0) ? 8'h30 : 8'h35;
               cmd(8'h00); adr4(c, r); cmd(b);
               expect_op("R3 rnd read", kind_for_confirm(b));
               chk("R3 rnd col", 32'(g_c), 32'(c));
               chk("R3 rnd row", 32'(g_r), 32'(r));
               clr_busy();
            end
            1: begin
               cmd(8'h80); adr4(c, r);
               repeat (int'($urandom_range(0, 3))) dat(8'($urandom));
               cmd(8'h10);
               expect_op("R5 rnd program", 4);
               chk("R5 rnd row", 32'(g_r), 32'(r));
               cmd(8'hFF);
            end
            2: begin
               cmd(8'h60); adr(r[7:0]); adr(r[15:8]); cmd(8'hD0);
               expect_op("R8 rnd erase", 8);
               chk("R8 rnd row", 32'(g_r), 32'(r));
               clr_busy();
            end
            default: begin
               b = 8'($urandom);
               if (!idle_defined(b)) begin
                  cmd(b);
                  expect_err("R10 rnd undefined");
               end
            end
         endcase
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule